// File: doc/BRIEF.md
# Periodic-Sample Wake-Up Input Debouncer

This block watches two slow, possibly noisy wake-up pins and decides when the always-on domain should power the core back up. The pins are brought through a synchronizer and looked at only on a sample tick that a programmable prescaler generates. A channel fires when the number of back-to-back samples at its own active level reaches a shared, programmable count. In front of the sampling instant, a power-enable output opens a window of programmable length, so external pull-ups or comparators only draw current around the sample.

A channel event sets a sticky per-channel flag that software can read and clear. It also drives a registered wake-up request that additionally merges the real-time-clock alarm, the real-time-timer alarm and the supply-monitor wake-up, each behind its own enable bit. When the clear-enable bit is set, an event also wipes the lower half of a small backup register bank at once. The bank has a plain write port and a combinational read port. All of the logic runs on the slow always-on clock.

Top module: `wkd_top`

## Requirements
- R1: An internal counter runs from 0 to `cfg_period` and then wraps to 0. A sample tick occurs on the cycle where the counter equals `cfg_period`, so there is one tick every `cfg_period`+1 cycles. The counter is 0 after reset.
- R2: `pwr_en_o` is high when the counter value plus `cfg_high` is at least `cfg_period`. It is therefore high for the last `cfg_high`+1 cycles of each period, including the tick cycle, and it stays high when `cfg_high` is at least `cfg_period`.
- R3: Each `wk_in` bit passes through a 2-flop synchronizer that resets to 0. On a tick, the synchronized bit is active when it equals its `cfg_pol` bit, where 1 means active-high and 0 means active-low.
- R4: The required run length is `cfg_samples` clamped to the range 2 to 8. Values 0 and 1 act as 2, and values 9 to 15 act as 8. A channel qualifies on the tick at which its consecutive active samples reach that length.
- R5: An inactive sample clears the channel's run and re-arms the channel. After it qualifies, a channel cannot qualify again until it has seen an inactive sample.
- R6: `sts_o[c]` is set at the clock edge of the qualifying sample and holds until an `sts_clr[c]` strobe. If a set and a clear fall on the same edge, the set wins.
- R7: A qualifying sample produces a one-cycle internal event. One edge later, `wake_o` goes high for a cycle. `wake_o` is a register that holds the OR of the channel events and the enabled external sources.
- R8: When the matching enable (`en_rtc`, `en_rtt`, `en_smon`) is set, `rtc_alarm`, `rtt_alarm` and `smon_wake` each drive `wake_o` one cycle later. No flag records these three sources.
- R9: The backup bank holds 8 words of 32 bits. All words are zero after reset. `bkp_we` writes `bkp_wdata` at `bkp_waddr` on the clock edge, and `bkp_rdata` shows the word at `bkp_raddr` without delay.
- R10: With `cfg_clr_en` set, words 0 to 3 become zero on the same edge that raises `wake_o` for a channel event, and this clear beats a write to those words. Words 4 to 7 are never cleared. With `cfg_clr_en` low, events leave the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | 4 | Sample period minus one |
| cfg_high | input | 3 | Power-enable window length minus one |
| cfg_samples | input | 4 | Consecutive active samples required (clamped 2..8) |
| cfg_pol | input | 2 | Active level per channel |
| cfg_clr_en | input | 1 | Allow events to clear the lower backup half |
| en_rtc | input | 1 | Enable RTC alarm wake-up |
| en_rtt | input | 1 | Enable RTT alarm wake-up |
| en_smon | input | 1 | Enable supply-monitor wake-up |
| wk_in | input | 2 | Asynchronous wake-up pins |
| rtc_alarm | input | 1 | RTC alarm request |
| rtt_alarm | input | 1 | RTT alarm request |
| smon_wake | input | 1 | Supply-monitor wake request |
| sts_clr | input | 2 | Per-channel status clear strobe |
| sts_o | output | 2 | Sticky per-channel event flags |
| wake_o | output | 1 | Registered core wake-up request |
| pwr_en_o | output | 1 | Input sampling power window |
| bkp_we | input | 1 | Backup write enable |
| bkp_waddr | input | 3 | Backup write word address |
| bkp_wdata | input | 32 | Backup write data |
| bkp_raddr | input | 3 | Backup read word address |
| bkp_rdata | output | 32 | Backup read data |

## Verification
A corrupted prescaler count shows up on `pwr_en_o` within one period and moves every later sample. A wrong run counter or arming bit shows up as an `sts_o` edge that comes a tick early, a tick late or a second time. That difference is visible at the qualifying edge, and on `wake_o` and the lower backup words one edge after it. A wrong bank word is visible the same cycle it is addressed on `bkp_rdata`, so the read address is swept at random every cycle to keep that delay short.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
   localparam int unsigned SAMP_W   = 4;
   localparam logic [SAMP_W-1:0] SAMP_MIN = 4'd2;
   localparam logic [SAMP_W-1:0] SAMP_MAX = 4'd8;

   typedef logic [SAMP_W-1:0] samp_t;

   // required run length, held inside the legal range
   function automatic samp_t clamp_samples(input samp_t v);
      if (v < SAMP_MIN) return SAMP_MIN;
      if (v > SAMP_MAX) return SAMP_MAX;
      return v;
   endfunction
endpackage

// File: rtl/wkd_tick_gen.sv
module wkd_tick_gen #(
   parameter int PER_W  = 4,
   parameter int HIGH_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PER_W-1:0]  period,
   input  logic [HIGH_W-1:0] high,
   output logic              tick,
   output logic              pwr_en
);
   localparam int SUM_W = ((PER_W > HIGH_W) ? PER_W : HIGH_W) + 1;

   logic [PER_W-1:0] cnt_q;
   logic [SUM_W-1:0] reach;

   assign tick   = (cnt_q >= period);
   assign reach  = SUM_W'(cnt_q) + SUM_W'(high);
   assign pwr_en = (reach >= SUM_W'(period));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + PER_W'(1);
   end
endmodule

// File: rtl/wkd_sync.sv
module wkd_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
            end else begin
               stg_q[0] <= d;
               for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
            end
         end
         assign q = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/wkd_channel.sv
module wkd_channel
   import wkd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  sample,
   input  logic  pol,
   input  samp_t req,
   input  logic  clr,
   output logic  sts,
   output logic  evt
);
   samp_t run_q;
   logic  armed_q;
   logic  act;
   logic  qual;
   logic [SAMP_W:0] run_inc;

   assign act     = (sample == pol);
   assign run_inc = {1'b0, run_q} + {{SAMP_W{1'b0}}, 1'b1};
   assign qual    = tick && act && armed_q && (run_inc >= {1'b0, req});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         armed_q <= 1'b1;
         evt     <= 1'b0;
         sts     <= 1'b0;
      end else begin
         evt <= qual;
         if (tick) begin
            if (act) begin
               run_q <= (run_q >= SAMP_MAX) ? SAMP_MAX : run_inc[SAMP_W-1:0];
               if (qual) armed_q <= 1'b0;
            end else begin
               run_q   <= '0;
               armed_q <= 1'b1;
            end
         end
         if (qual)     sts <= 1'b1;
         else if (clr) sts <= 1'b0;
      end
   end
endmodule

// File: rtl/wkd_backup_bank.sv
module wkd_backup_bank #(
   parameter int WORDS = 8,
   parameter int W     = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] waddr,
   input  logic [W-1:0]             wdata,
   input  logic [$clog2(WORDS)-1:0] raddr,
   output logic [W-1:0]             rdata,
   input  logic                     wipe
);
   localparam int AW   = $clog2(WORDS);
   localparam int HALF = WORDS / 2;

   logic [W-1:0] mem_q [WORDS];

   generate
      for (genvar i = 0; i < WORDS; i++) begin : g_word
         logic hit;
         assign hit = we && (waddr == AW'(i));
         if (i < HALF) begin : g_low
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)    mem_q[i] <= '0;
               else if (wipe) mem_q[i] <= '0;
               else if (hit)  mem_q[i] <= wdata;
            end
         end else begin : g_high
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   mem_q[i] <= '0;
               else if (hit) mem_q[i] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/wkd_top.sv
module wkd_top
   import wkd_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int PER_W       = 4,
   parameter int HIGH_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int BKP_WORDS   = 8,
   parameter int BKP_W       = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PER_W-1:0]             cfg_period,
   input  logic [HIGH_W-1:0]            cfg_high,
   input  logic [SAMP_W-1:0]            cfg_samples,
   input  logic [NCH-1:0]               cfg_pol,
   input  logic                         cfg_clr_en,
   input  logic                         en_rtc,
   input  logic                         en_rtt,
   input  logic                         en_smon,
   input  logic [NCH-1:0]               wk_in,
   input  logic                         rtc_alarm,
   input  logic                         rtt_alarm,
   input  logic                         smon_wake,
   input  logic [NCH-1:0]               sts_clr,
   output logic [NCH-1:0]               sts_o,
   output logic                         wake_o,
   output logic                         pwr_en_o,
   input  logic                         bkp_we,
   input  logic [$clog2(BKP_WORDS)-1:0] bkp_waddr,
   input  logic [BKP_W-1:0]             bkp_wdata,
   input  logic [$clog2(BKP_WORDS)-1:0] bkp_raddr,
   output logic [BKP_W-1:0]             bkp_rdata
);
   generate
      if (NCH < 1 || PER_W < 1 || HIGH_W < 1 || SYNC_STAGES < 0) begin : g_bad_cfg
         $error("wkd_top: channel count, field widths or sync depth out of range");
      end
      if (BKP_WORDS < 2 || (BKP_WORDS & (BKP_WORDS - 1)) != 0) begin : g_bad_bank
         $error("wkd_top: backup bank depth must be a power of two of at least 2");
      end
   endgenerate

   logic           tick_w;
   logic [NCH-1:0] wk_sync;
   logic [NCH-1:0] evt_w;
   logic           ext_wake;
   samp_t          req_w;

   assign req_w = clamp_samples(cfg_samples);

   wkd_tick_gen #(.PER_W(PER_W), .HIGH_W(HIGH_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .period(cfg_period), .high(cfg_high),
      .tick(tick_w), .pwr_en(pwr_en_o)
   );

   wkd_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(wk_in), .q(wk_sync)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         wkd_channel u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick_w), .sample(wk_sync[c]),
            .pol(cfg_pol[c]), .req(req_w), .clr(sts_clr[c]),
            .sts(sts_o[c]), .evt(evt_w[c])
         );
      end
   endgenerate

   assign ext_wake = (rtc_alarm && en_rtc) || (rtt_alarm && en_rtt) || (smon_wake && en_smon);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_o <= 1'b0;
      else        wake_o <= (|evt_w) || ext_wake;
   end

   wkd_backup_bank #(.WORDS(BKP_WORDS), .W(BKP_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bkp_we), .waddr(bkp_waddr), .wdata(bkp_wdata),
      .raddr(bkp_raddr), .rdata(bkp_rdata), .wipe(cfg_clr_en && (|evt_w))
   );
endmodule

// File: rtl/wkd_checker.sv
module wkd_checker #(
   parameter int NCH   = 2,
   parameter int WORDS = 8,
   parameter int BKP_W = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     tick,
   input logic                     pwr_en,
   input logic [NCH-1:0]           evt,
   input logic [NCH-1:0]           sts,
   input logic [NCH-1:0]           sts_clr,
   input logic                     wake,
   input logic                     rtc_alarm,
   input logic                     rtt_alarm,
   input logic                     smon_wake,
   input logic                     en_rtc,
   input logic                     en_rtt,
   input logic                     en_smon,
   input logic                     clr_en,
   input logic [$clog2(WORDS)-1:0] raddr,
   input logic [BKP_W-1:0]         rdata
);
   localparam int HALF = WORDS / 2;

   logic any_src;
   assign any_src = (|evt) || (rtc_alarm && en_rtc) || (rtt_alarm && en_rtt) || (smon_wake && en_smon);

   p_tick_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> pwr_en);

   p_wake_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(any_src));

   p_lower_wiped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr_en && (|evt)) && (int'(raddr) < HALF)) |-> (rdata == '0));

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_chk
         p_set_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts[c]) |-> $past(tick));
         p_clear_by_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sts[c]) |-> $past(sts_clr[c]));
         p_single_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
            evt[c] |=> !evt[c]);
      end
   endgenerate
endmodule

bind wkd_top wkd_checker #(.NCH(NCH), .WORDS(BKP_WORDS), .BKP_W(BKP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_w), .pwr_en(pwr_en_o), .evt(evt_w),
   .sts(sts_o), .sts_clr(sts_clr), .wake(wake_o), .rtc_alarm(rtc_alarm),
   .rtt_alarm(rtt_alarm), .smon_wake(smon_wake), .en_rtc(en_rtc), .en_rtt(en_rtt),
   .en_smon(en_smon), .clr_en(cfg_clr_en), .raddr(bkp_raddr), .rdata(bkp_rdata)
);

// File: tb/tb_wkd_top.sv
module tb_wkd_top;
   localparam int NCH = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic [3:0]  cfg_period;
   logic [2:0]  cfg_high;
   logic [3:0]  cfg_samples;
   logic [1:0]  cfg_pol;
   logic        cfg_clr_en, en_rtc, en_rtt, en_smon;
   logic [1:0]  wk_in;
   logic        rtc_alarm, rtt_alarm, smon_wake;
   logic [1:0]  sts_clr;
   logic [1:0]  sts_o;
   logic        wake_o, pwr_en_o;
   logic        bkp_we;
   logic [2:0]  bkp_waddr, bkp_raddr;
   logic [31:0] bkp_wdata, bkp_rdata;

   wkd_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_high(cfg_high),
      .cfg_samples(cfg_samples), .cfg_pol(cfg_pol), .cfg_clr_en(cfg_clr_en),
      .en_rtc(en_rtc), .en_rtt(en_rtt), .en_smon(en_smon), .wk_in(wk_in),
      .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm), .smon_wake(smon_wake),
      .sts_clr(sts_clr), .sts_o(sts_o), .wake_o(wake_o), .pwr_en_o(pwr_en_o),
      .bkp_we(bkp_we), .bkp_waddr(bkp_waddr), .bkp_wdata(bkp_wdata),
      .bkp_raddr(bkp_raddr), .bkp_rdata(bkp_rdata)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   // reference model state, built from the requirements
   int          m_cnt;
   logic [1:0]  m_s1, m_s2, m_evt, m_sts, m_armed;
   int          m_run [NCH];
   logic        m_wake;
   logic [31:0] m_bank [8];

   function automatic int req_len(input logic [3:0] v);   // R4 clamp 2..8
      if (v < 4'd2) return 2;
      if (v > 4'd8) return 8;
      return int'(v);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_s1 <= '0; m_s2 <= '0; m_evt <= '0; m_sts <= '0;
         m_armed <= '1; m_wake <= 1'b0;
         for (int c = 0; c < NCH; c++) m_run[c] <= 0;
         for (int i = 0; i < 8; i++) m_bank[i] <= '0;
      end else begin
         logic tk;
         logic [1:0] q;
         tk = (m_cnt >= int'(cfg_period));                 // R1
         m_cnt <= tk ? 0 : m_cnt + 1;
         m_s1 <= wk_in; m_s2 <= m_s1;                       // R3
         for (int c = 0; c < NCH; c++) begin
            logic act;
            act  = (m_s2[c] == cfg_pol[c]);
            q[c] = tk && act && m_armed[c] && (m_run[c] + 1 >= req_len(cfg_samples));
            if (tk) begin
               if (act) begin
                  m_run[c] <= (m_run[c] >= 8) ? 8 : m_run[c] + 1;
                  if (q[c]) m_armed[c] <= 1'b0;
               end else begin
                  m_run[c] <= 0; m_armed[c] <= 1'b1;       // R5
               end
            end
            if (q[c]) m_sts[c] <= 1'b1;                     // R6
            else if (sts_clr[c]) m_sts[c] <= 1'b0;
         end
         m_evt  <= q;
         m_wake <= (|m_evt) || (rtc_alarm && en_rtc) || (rtt_alarm && en_rtt)
                   || (smon_wake && en_smon);               // R7 R8
         for (int i = 0; i < 8; i++) begin
            if (cfg_clr_en && (|m_evt) && i < 4) m_bank[i] <= '0;   // R10
            else if (bkp_we && int'(bkp_waddr) == i) m_bank[i] <= bkp_wdata;  // R9
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   task automatic compare_all();
      logic exp_pwr;
      exp_pwr = (m_cnt + int'(cfg_high)) >= int'(cfg_period);
      chk("R1/R2 pwr_en window", {31'd0, pwr_en_o}, {31'd0, exp_pwr});
      chk("R3/R4/R5/R6 status flags", {30'd0, sts_o}, {30'd0, m_sts});
      chk("R7/R8 wake request", {31'd0, wake_o}, {31'd0, m_wake});
      chk("R9/R10 backup read", bkp_rdata, m_bank[bkp_raddr]);
   endtask

   task automatic drive_idle();
      wk_in = '0; rtc_alarm = 0; rtt_alarm = 0; smon_wake = 0; sts_clr = '0;
      bkp_we = 0; bkp_waddr = '0; bkp_wdata = '0; bkp_raddr = '0;
   endtask

   task automatic reset_with(input logic [3:0] per, input logic [2:0] hi, input logic [3:0] smp,
                             input logic [1:0] pol, input logic clr, input logic [2:0] ens);
      @(negedge clk);
      rst_n = 0; drive_idle();
      cfg_period = per; cfg_high = hi; cfg_samples = smp; cfg_pol = pol;
      cfg_clr_en = clr; {en_rtc, en_rtt, en_smon} = ens;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   // random run: inputs drift slowly so real runs form
   task automatic run_random(input int ncyc);
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         compare_all();
         if ($urandom % 10 == 0) wk_in[0] = ~wk_in[0];
         if ($urandom % 13 == 0) wk_in[1] = ~wk_in[1];
         rtc_alarm = ($urandom % 40 == 0);
         rtt_alarm = ($urandom % 45 == 0);
         smon_wake = ($urandom % 50 == 0);
         sts_clr   = {($urandom % 25 == 0), ($urandom % 25 == 0)};
         bkp_we    = ($urandom % 4 == 0);
         bkp_waddr = 3'($urandom);
         bkp_wdata = $urandom;
         bkp_raddr = 3'($urandom);
      end
   endtask

   // constant input run: exercises exact qualify timing
   task automatic run_hold(input logic [1:0] lvl, input int ncyc);
      wk_in = lvl;
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         compare_all();
         bkp_raddr = 3'(k);
         bkp_we    = (k % 3 == 0);
         bkp_waddr = 3'(k + 1);
         bkp_wdata = 32'hA5A5_0000 + 32'(k);
      end
   endtask

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd7411);
      rst_n = 0; drive_idle();
      cfg_period = 4'd3; cfg_high = 3'd1; cfg_samples = 4'd3; cfg_pol = 2'b11;
      cfg_clr_en = 1; en_rtc = 1; en_rtt = 1; en_smon = 1;
      repeat (3) @(negedge clk);
      // R9 reset state: flags, wake and every bank word are zero
      chk("R6 reset flags", {30'd0, sts_o}, 32'd0);
      chk("R7 reset wake", {31'd0, wake_o}, 32'd0);
      for (int i = 0; i < 8; i++) begin
         bkp_raddr = 3'(i); #1;
         chk("R9 reset bank word", bkp_rdata, 32'd0);
      end
      rst_n = 1;

      // R4 lower clamp: samples=0 behaves as 2, both channels active-high
      reset_with(4'd2, 3'd0, 4'd0, 2'b11, 1'b1, 3'b000);
      run_hold(2'b11, 60);
      // R4 upper clamp: samples=15 behaves as 8, active-low, clear disabled (R10)
      reset_with(4'd2, 3'd5, 4'd15, 2'b00, 1'b0, 3'b000);
      run_hold(2'b00, 80);
      // R1 tick every cycle with period 0 and mixed polarity; R5 rearm
      reset_with(4'd0, 3'd0, 4'd2, 2'b01, 1'b1, 3'b111);
      run_hold(2'b01, 20);
      run_hold(2'b10, 20);
      run_hold(2'b01, 20);

      // constrained random configurations
      for (int p = 0; p < 24; p++) begin
         reset_with(4'(2 + $urandom % 6), 3'($urandom), 4'($urandom), 2'($urandom),
                    1'($urandom), 3'($urandom));
         run_random(500);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL R1 watchdog: actual %0d cycles expected below 150000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule